// File: doc/BRIEF.md
# Wavefront Issue Scheduler for a Four-SIMD Compute Unit

This block decides, cycle by cycle, which wavefront in a compute unit may issue its next instruction. It holds ten wavefront slots for each of four vector SIMDs, forty slots in all. Each slot records whether a wavefront lives there, whether the decoder has handed it a next instruction, whether that instruction is vector or scalar work, and whether the slot still waits on an earlier instruction of its own.

The SIMDs take turns in a fixed four-cycle rotation. In the cycle that belongs to a SIMD, the scheduler chooses the oldest ready vector instruction among that SIMD's slots and strobes it to the SIMD. In the same cycle it chooses the oldest ready scalar or control-flow instruction among the same slots and strobes it to the shared scalar port. A slot that is stalled is passed over in favour of any other ready slot, whatever task that slot belongs to. A slot never holds more than one instruction, and once that instruction issues the slot stays blocked until a completion pulse arrives, so each wavefront remains in program order.

Allocation, release, instruction delivery and completion arrive as per-cycle requests. Requests that make no sense (allocating into a live slot, releasing an empty one) are dropped and raise a sticky error flag.

Top module: `wf_issue_sched`

## Requirements
- R1: There are 4 SIMDs with 10 slots each. Global slot id = SIMD index × 10 + local index, so ids 0..39 are valid. The vector slot output carries the local index and the scalar slot output carries the global id.
- R2: A turn counter starts at SIMD 0 on the first cycle after reset and advances by one SIMD (wrapping 3 to 0) on every clock. A vector strobe appears only for the SIMD whose turn it is, and at most one per cycle.
- R3: The scalar port issues at most one instruction per cycle, and only from a slot of the SIMD whose turn it is. An instruction tagged scalar (push_scalar_i = 1) never appears on a vector strobe.
- R4: An instruction tagged vector (push_scalar_i = 0) issues only on the vector strobe of the SIMD that owns its slot.
- R5: A slot is ready when it is allocated, holds an instruction, and does not wait for completion. A slot that is not ready is skipped, and the oldest ready slot of the same kind on that SIMD issues instead.
- R6: Among ready slots of one SIMD and one kind, the slot allocated earliest issues first. The lowest local index wins if no age order exists.
- R7: A slot holds at most one instruction. A push to a slot that already holds one, or to an empty slot, is ignored. After an instruction issues, the slot issues nothing more until a dep_clr_i pulse for that slot arrives and a new instruction has been pushed.
- R8: Releasing a slot empties it. A later allocation of the same slot makes it the youngest of its SIMD.
- R9: An allocation into an occupied slot or to an id of 40 or more, and a release of an empty slot, are ignored: the slot's contents and age are unchanged. err_o is set and stays set until reset.
- R10: Reset empties all slots, clears err_o and returns the rotation to SIMD 0. No strobe is active after reset until work is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alloc_vld_i | input | 1 | Allocate the slot named by alloc_id_i |
| alloc_id_i | input | 6 | Global slot id to allocate |
| free_vld_i | input | 1 | Release the slot named by free_id_i |
| free_id_i | input | 6 | Global slot id to release |
| push_i | input | 40 | Per-slot pulse: next decoded instruction delivered |
| push_scalar_i | input | 40 | Per-slot kind of the pushed instruction (1 scalar/control, 0 vector) |
| dep_clr_i | input | 40 | Per-slot pulse: the issued instruction has completed |
| vec_issue_o | output | 4 | Per-SIMD vector issue strobe |
| vec_slot_o | output | 16 | Local slot index per SIMD (4 bits each, SIMD 0 in the low bits) |
| sc_issue_o | output | 1 | Scalar port issue strobe |
| sc_slot_o | output | 6 | Global slot id of the scalar issue |
| err_o | output | 1 | Sticky error flag for invalid allocate/release |

## Verification
The bench builds the block with its default parameters: four SIMDs and ten slots each. This is the full rotation and the full slot set, so turn order, the mapping from global id to local index, and an out-of-range allocation id (45) can all be exercised. Ten slots per SIMD leave room to set three-way age orders on one SIMD, to mix vector and scalar work on a single turn, and to stall one slot while another on the same SIMD goes ahead.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // State kept for one wavefront slot.
  typedef struct packed {
    logic occ;     // wavefront allocated
    logic pend;    // holds a next instruction not yet issued
    logic busy;    // issued instruction awaiting completion
    logic scalar;  // kind of the held instruction
  } slot_state_t;

endpackage

// File: rtl/wfs_age_pick.sv
module wfs_age_pick #(
  parameter int N   = 10,
  parameter int IDW = 4
) (
  input  logic [N-1:0]   req_i,
  input  logic [N*N-1:0] older_i,  // entry j*N+i set: slot j is older than slot i
  output logic           hit_o,
  output logic [IDW-1:0] id_o,
  output logic [N-1:0]   oh_o
);

  logic [N-1:0] blocked;
  logic [N-1:0] cand;

  // A requester is blocked when any other requester is older.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i) blocked[i] = blocked[i] | (req_i[j] & older_i[j*N+i]);
      end
      cand[i] = req_i[i] & ~blocked[i];
    end
  end

  // The lowest index among unblocked requesters wins.
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    oh_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !hit_o) begin
        hit_o    = 1'b1;
        id_o     = IDW'(i);
        oh_o[i]  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wfs_bank.sv
module wfs_bank
  import sched_pkg::*;
#(
  parameter int SLOTS = 10,
  parameter int LID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             turn_i,
  input  logic [SLOTS-1:0] alloc_i,
  input  logic [SLOTS-1:0] free_i,
  input  logic [SLOTS-1:0] push_i,
  input  logic [SLOTS-1:0] push_sc_i,
  input  logic [SLOTS-1:0] clr_i,
  output logic [SLOTS-1:0] occ_o,
  output logic             vec_gnt_o,
  output logic [LID_W-1:0] vec_id_o,
  output logic             sc_gnt_o,
  output logic [LID_W-1:0] sc_id_o
);

  localparam int AGE_BITS = SLOTS * SLOTS;

  slot_state_t         st_q [SLOTS];
  slot_state_t         st_d [SLOTS];
  logic [AGE_BITS-1:0] older_q, older_d;

  logic [SLOTS-1:0] rdy_vec, rdy_sc;
  logic [SLOTS-1:0] vec_oh, sc_oh;
  logic [SLOTS-1:0] iss_vec, iss_sc;
  logic [SLOTS-1:0] take;
  logic             vec_hit, sc_hit;
  logic             st_en, age_en;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      occ_o[i]   = st_q[i].occ;
      rdy_vec[i] = st_q[i].occ & st_q[i].pend & ~st_q[i].busy & ~st_q[i].scalar;
      rdy_sc[i]  = st_q[i].occ & st_q[i].pend & ~st_q[i].busy &  st_q[i].scalar;
    end
  end

  wfs_age_pick #(.N(SLOTS), .IDW(LID_W)) u_pick_vec (
    .req_i   (rdy_vec),
    .older_i (older_q),
    .hit_o   (vec_hit),
    .id_o    (vec_id_o),
    .oh_o    (vec_oh)
  );

  wfs_age_pick #(.N(SLOTS), .IDW(LID_W)) u_pick_sc (
    .req_i   (rdy_sc),
    .older_i (older_q),
    .hit_o   (sc_hit),
    .id_o    (sc_id_o),
    .oh_o    (sc_oh)
  );

  assign vec_gnt_o = turn_i & vec_hit;
  assign sc_gnt_o  = turn_i & sc_hit;
  assign iss_vec   = turn_i ? vec_oh : '0;
  assign iss_sc    = turn_i ? sc_oh  : '0;
  assign take      = alloc_i & ~occ_o;

  // Slot state next value.
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      st_d[i] = st_q[i];
      if (free_i[i] && st_q[i].occ) begin
        st_d[i] = '0;
      end else if (take[i]) begin
        st_d[i]     = '0;
        st_d[i].occ = 1'b1;
      end else if (st_q[i].occ) begin
        if (iss_vec[i] || iss_sc[i]) begin
          st_d[i].pend = 1'b0;
          st_d[i].busy = 1'b1;
        end
        if (clr_i[i] && st_q[i].busy) st_d[i].busy = 1'b0;
        if (push_i[i] && !st_q[i].pend) begin
          st_d[i].pend   = 1'b1;
          st_d[i].scalar = push_sc_i[i];
        end
      end
    end
  end

  // Age matrix: a newly taken slot becomes younger than every other slot.
  always_comb begin
    older_d = older_q;
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = 0; j < SLOTS; j++) begin
        if (take[j] && (i != j))  older_d[i*SLOTS+j] = 1'b1;
        else if (take[i])         older_d[i*SLOTS+j] = 1'b0;
      end
    end
  end

  assign st_en  = (|(alloc_i | free_i | push_i | clr_i)) | vec_gnt_o | sc_gnt_o;
  assign age_en = |take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) st_q[i] <= '0;
    end else if (st_en) begin
      for (int i = 0; i < SLOTS; i++) st_q[i] <= st_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      older_q <= '0;
    else if (age_en) older_q <= older_d;
  end

endmodule

// File: rtl/wf_issue_sched.sv
module wf_issue_sched #(
  parameter int NUM_SIMD       = 4,
  parameter int SLOTS_PER_SIMD = 10,
  localparam int NSLOT  = NUM_SIMD * SLOTS_PER_SIMD,
  localparam int GID_W  = $clog2(NSLOT),
  localparam int LID_W  = $clog2(SLOTS_PER_SIMD),
  localparam int TURN_W = $clog2(NUM_SIMD)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_vld_i,
  input  logic [GID_W-1:0]          alloc_id_i,
  input  logic                      free_vld_i,
  input  logic [GID_W-1:0]          free_id_i,
  input  logic [NSLOT-1:0]          push_i,
  input  logic [NSLOT-1:0]          push_scalar_i,
  input  logic [NSLOT-1:0]          dep_clr_i,
  output logic [NUM_SIMD-1:0]       vec_issue_o,
  output logic [NUM_SIMD*LID_W-1:0] vec_slot_o,
  output logic                      sc_issue_o,
  output logic [GID_W-1:0]          sc_slot_o,
  output logic                      err_o
);

  localparam int ID_SPACE = 2 ** GID_W;

  logic [TURN_W-1:0]   turn_q, turn_d;
  logic [NSLOT-1:0]    alloc_oh, free_oh, occ_all;
  logic [ID_SPACE-1:0] occ_ext;
  logic [NUM_SIMD-1:0] sc_gnt;
  logic [LID_W-1:0]    sc_id  [NUM_SIMD];
  logic [LID_W-1:0]    vec_id [NUM_SIMD];
  logic                bad_req, err_q, err_d;

  // Request decode.
  always_comb begin
    for (int g = 0; g < NSLOT; g++) begin
      alloc_oh[g] = alloc_vld_i && (alloc_id_i == GID_W'(g));
      free_oh[g]  = free_vld_i  && (free_id_i  == GID_W'(g));
    end
  end

  assign occ_ext = ID_SPACE'(occ_all);
  assign bad_req = (alloc_vld_i && occ_ext[alloc_id_i]) ||
                   (alloc_vld_i && (int'(alloc_id_i) >= NSLOT)) ||
                   (free_vld_i  && !occ_ext[free_id_i]);

  // Fixed rotation over the SIMDs.
  always_comb begin
    if (turn_q == TURN_W'(NUM_SIMD - 1)) turn_d = '0;
    else                                 turn_d = turn_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) turn_q <= '0;
    else        turn_q <= turn_d;
  end

  generate
    for (genvar s = 0; s < NUM_SIMD; s++) begin : g_bank
      wfs_bank #(.SLOTS(SLOTS_PER_SIMD), .LID_W(LID_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .turn_i    (turn_q == TURN_W'(s)),
        .alloc_i   (alloc_oh[s*SLOTS_PER_SIMD +: SLOTS_PER_SIMD]),
        .free_i    (free_oh[s*SLOTS_PER_SIMD +: SLOTS_PER_SIMD]),
        .push_i    (push_i[s*SLOTS_PER_SIMD +: SLOTS_PER_SIMD]),
        .push_sc_i (push_scalar_i[s*SLOTS_PER_SIMD +: SLOTS_PER_SIMD]),
        .clr_i     (dep_clr_i[s*SLOTS_PER_SIMD +: SLOTS_PER_SIMD]),
        .occ_o     (occ_all[s*SLOTS_PER_SIMD +: SLOTS_PER_SIMD]),
        .vec_gnt_o (vec_issue_o[s]),
        .vec_id_o  (vec_id[s]),
        .sc_gnt_o  (sc_gnt[s]),
        .sc_id_o   (sc_id[s])
      );
      assign vec_slot_o[s*LID_W +: LID_W] = vec_id[s];
    end
  endgenerate

  // Shared scalar port follows the current turn.
  always_comb begin
    sc_issue_o = 1'b0;
    sc_slot_o  = '0;
    for (int s = 0; s < NUM_SIMD; s++) begin
      if (turn_q == TURN_W'(s)) begin
        sc_issue_o = sc_gnt[s];
        sc_slot_o  = GID_W'(s * SLOTS_PER_SIMD) + GID_W'(sc_id[s]);
      end
    end
  end

  // Sticky error flag.
  assign err_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (bad_req) err_q <= err_d;
  end

  assign err_o = err_q;

endmodule

// File: rtl/wf_issue_sched_chk.sv
module wf_issue_sched_chk #(
  parameter int NUM_SIMD       = 4,
  parameter int SLOTS_PER_SIMD = 10,
  localparam int NSLOT  = NUM_SIMD * SLOTS_PER_SIMD,
  localparam int GID_W  = $clog2(NSLOT),
  localparam int TURN_W = $clog2(NUM_SIMD)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_vld_i,
  input logic [GID_W-1:0]    alloc_id_i,
  input logic                free_vld_i,
  input logic [GID_W-1:0]    free_id_i,
  input logic [NSLOT-1:0]    occ_i,
  input logic [NUM_SIMD-1:0] vec_issue_i,
  input logic                sc_issue_i,
  input logic [GID_W-1:0]    sc_slot_i,
  input logic                err_i
);

  logic [TURN_W-1:0] ph_q;
  logic [(2**GID_W)-1:0] occ_x;
  logic misuse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ph_q <= '0;
    else if (ph_q == TURN_W'(NUM_SIMD - 1))  ph_q <= '0;
    else                                     ph_q <= ph_q + 1'b1;
  end

  assign occ_x  = (2**GID_W)'(occ_i);
  assign misuse = (alloc_vld_i && (occ_x[alloc_id_i] || int'(alloc_id_i) >= NSLOT)) ||
                  (free_vld_i && !occ_x[free_id_i]);

  a_r2_single_vec: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_issue_i));

  a_r2_vec_on_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (|vec_issue_i) |-> (vec_issue_i == (NUM_SIMD'(1) << ph_q)));

  a_r3_scalar_on_turn: assert property (@(posedge clk) disable iff (!rst_n)
    sc_issue_i |-> ((int'(sc_slot_i) / SLOTS_PER_SIMD) == int'(ph_q)));

  a_r1_scalar_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    sc_issue_i |-> (int'(sc_slot_i) < NSLOT));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> err_i);

  a_r9_err_on_misuse: assert property (@(posedge clk) disable iff (!rst_n)
    misuse |=> err_i);

endmodule

bind wf_issue_sched wf_issue_sched_chk #(
  .NUM_SIMD       (NUM_SIMD),
  .SLOTS_PER_SIMD (SLOTS_PER_SIMD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_vld_i (alloc_vld_i),
  .alloc_id_i  (alloc_id_i),
  .free_vld_i  (free_vld_i),
  .free_id_i   (free_id_i),
  .occ_i       (occ_all),
  .vec_issue_i (vec_issue_o),
  .sc_issue_i  (sc_issue_o),
  .sc_slot_i   (sc_slot_o),
  .err_i       (err_o)
);

// File: tb/wf_issue_sched_tb.sv
module wf_issue_sched_tb;

  localparam int NS    = 4;
  localparam int SPS   = 10;
  localparam int NSLOT = NS * SPS;
  localparam int GID_W = $clog2(NSLOT);
  localparam int LID_W = $clog2(SPS);

  typedef struct {
    bit    scalar;
    int    simd;
    int    slot;
    string req;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 alloc_vld_i = 1'b0;
  logic [GID_W-1:0]     alloc_id_i = '0;
  logic                 free_vld_i = 1'b0;
  logic [GID_W-1:0]     free_id_i = '0;
  logic [NSLOT-1:0]     push_i = '0;
  logic [NSLOT-1:0]     push_scalar_i = '0;
  logic [NSLOT-1:0]     dep_clr_i = '0;
  logic [NS-1:0]        vec_issue_o;
  logic [NS*LID_W-1:0]  vec_slot_o;
  logic                 sc_issue_o;
  logic [GID_W-1:0]     sc_slot_o;
  logic                 err_o;

  int   n_chk = 0;
  int   n_bad = 0;
  int   ph    = 0;
  bit   done  = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  wf_issue_sched #(.NUM_SIMD(NS), .SLOTS_PER_SIMD(SPS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld_i(alloc_vld_i), .alloc_id_i(alloc_id_i),
    .free_vld_i(free_vld_i), .free_id_i(free_id_i),
    .push_i(push_i), .push_scalar_i(push_scalar_i), .dep_clr_i(dep_clr_i),
    .vec_issue_o(vec_issue_o), .vec_slot_o(vec_slot_o),
    .sc_issue_o(sc_issue_o), .sc_slot_o(sc_slot_o), .err_o(err_o)
  );

  // Bench's own view of whose turn it is (R2).
  always @(posedge clk) begin
    if (!rst_n) ph <= 0;
    else        ph <= (ph + 1) % NS;
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic expect_issue(bit scalar, int slot, string req);
    exp_t e;
    e.scalar = scalar; e.simd = slot / SPS; e.slot = slot; e.req = req;
    q.push_back(e);
  endtask

  task automatic observe(bit scalar, int simd, int slot);
    int idx = -1;
    foreach (q[k]) if (idx < 0 && q[k].scalar == scalar && q[k].simd == simd) idx = k;
    if (idx < 0) begin
      check(1'b0, "R7", scalar ? "unexpected scalar issue slot" : "unexpected vector issue slot",
            slot, -1);
    end else begin
      check(slot == q[idx].slot, q[idx].req, "issue order slot", slot, q[idx].slot);
      q.delete(idx);
    end
  endtask

  // Monitor: outputs depend only on registered state, so negedge sampling is safe.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int s = 0; s < NS; s++) begin
        if (vec_issue_o[s]) begin
          check(s == ph, "R2", "vector strobe SIMD vs turn", s, ph);
          observe(1'b0, s, s * SPS + int'(vec_slot_o[s*LID_W +: LID_W]));
        end
      end
      if (sc_issue_o) begin
        check(int'(sc_slot_o) / SPS == ph, "R3", "scalar SIMD vs turn", int'(sc_slot_o) / SPS, ph);
        observe(1'b1, int'(sc_slot_o) / SPS, int'(sc_slot_o));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_alloc(int g);
    alloc_vld_i = 1'b1; alloc_id_i = GID_W'(g);
    @(negedge clk);
    alloc_vld_i = 1'b0;
  endtask

  task automatic do_free(int g);
    free_vld_i = 1'b1; free_id_i = GID_W'(g);
    @(negedge clk);
    free_vld_i = 1'b0;
  endtask

  task automatic do_push(logic [NSLOT-1:0] vmask, logic [NSLOT-1:0] smask,
                         logic [NSLOT-1:0] cmask);
    push_i = vmask | smask; push_scalar_i = smask; dep_clr_i = cmask;
    @(negedge clk);
    push_i = '0; push_scalar_i = '0; dep_clr_i = '0;
  endtask

  function automatic logic [NSLOT-1:0] b(int g);
    return NSLOT'(1) << g;
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    check(err_o == 1'b0, "R10", "err after reset", int'(err_o), 0);
    check(vec_issue_o == '0 && sc_issue_o == 1'b0, "R10", "strobes after reset",
          int'(vec_issue_o), 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    apply_reset();
    idle(5);
    check(vec_issue_o == '0 && sc_issue_o == 1'b0, "R10", "no issue with empty slots",
          int'(vec_issue_o), 0);

    // R1 R3 R4: vector and scalar work on SIMD0/SIMD1.
    do_alloc(0); do_alloc(10); do_alloc(11);
    expect_issue(1'b0, 0, "R4");
    expect_issue(1'b0, 10, "R1");
    expect_issue(1'b1, 11, "R3");
    do_push(b(0) | b(10), b(11), '0);
    idle(10);
    check(q.size() == 0, "R4", "pending expectations", q.size(), 0);
    check(err_o == 1'b0, "R9", "no error on legal use", int'(err_o), 0);

    // R6 R9: age order on SIMD2; realloc of a live slot ignored.
    do_alloc(25); do_alloc(21);
    do_alloc(25);
    check(err_o == 1'b1, "R9", "err on alloc into occupied", int'(err_o), 1);
    do_alloc(23);
    expect_issue(1'b0, 25, "R6");
    expect_issue(1'b0, 21, "R6");
    expect_issue(1'b0, 23, "R9");
    do_push(b(21) | b(23) | b(25), '0, '0);
    idle(16);
    check(q.size() == 0, "R6", "pending expectations", q.size(), 0);
    do_push('0, '0, b(21) | b(23) | b(25));

    // R8: released and reallocated slot becomes youngest.
    do_free(25); do_alloc(25);
    expect_issue(1'b0, 21, "R8");
    expect_issue(1'b0, 23, "R8");
    expect_issue(1'b0, 25, "R8");
    do_push(b(21) | b(23) | b(25), '0, '0);
    idle(16);
    check(q.size() == 0, "R8", "pending expectations", q.size(), 0);

    // R5 R7: stalled old slot skipped for a younger ready one.
    do_alloc(30); do_alloc(31);
    expect_issue(1'b0, 30, "R5");
    do_push(b(30), '0, '0);
    idle(8);
    expect_issue(1'b0, 31, "R5");
    do_push(b(30) | b(31), '0, '0);
    idle(12);
    check(q.size() == 0, "R7", "stalled slot held back", q.size(), 0);
    expect_issue(1'b0, 30, "R7");
    do_push('0, '0, b(30));
    idle(8);
    check(q.size() == 0, "R5", "stalled slot resumes after clear", q.size(), 0);

    // R7: second push while one is held is ignored (kind must stay vector).
    do_push(b(30), '0, '0);
    do_push('0, b(30), '0);
    expect_issue(1'b0, 30, "R7");
    do_push('0, '0, b(30));
    idle(12);
    check(q.size() == 0, "R7", "single held instruction", q.size(), 0);

    // R3 R6: scalar oldest-first on SIMD0 alongside a vector issue.
    do_alloc(3); do_alloc(2);
    expect_issue(1'b1, 3, "R3");
    expect_issue(1'b1, 2, "R6");
    expect_issue(1'b0, 0, "R4");
    do_push(b(0), b(2) | b(3), b(0));
    idle(12);
    check(q.size() == 0, "R3", "pending expectations", q.size(), 0);

    // R10 R9: second reset empties slots; release of empty slot flags error.
    apply_reset();
    do_push(b(10), '0, '0);
    idle(8);
    check(q.size() == 0, "R7", "push to empty slot ignored", q.size(), 0);
    check(err_o == 1'b0, "R10", "err clear before misuse", int'(err_o), 0);
    do_free(10);
    check(err_o == 1'b1, "R9", "err on release of empty slot", int'(err_o), 1);
    apply_reset();
    do_alloc(45);
    check(err_o == 1'b1, "R9", "err on out-of-range alloc", int'(err_o), 1);
    idle(4);
    check(err_o == 1'b1, "R9", "err stays set", int'(err_o), 1);
    check(vec_issue_o == '0 && sc_issue_o == 1'b0, "R9", "ignored alloc made no wavefront",
          int'(vec_issue_o), 0);
    idle(4);
    check(q.size() == 0, "R7", "final queue empty", q.size(), 0);
    finish_run();
  end

endmodule